// File: doc/BRIEF.md
# Programmable Watchdog Timer with Reset/Interrupt Steering

This block supervises a host processor. The host arms it by writing one 8-bit configuration byte. The byte holds three fields: a 5-bit multiplier, a 2-bit resolution code and a steering bit. The timeout equals the multiplier times the selected resolution. The resolution is counted from two prescaler enables, a 16 Hz tick and a 1 Hz tick. Each tick is high for one clock cycle. The host keeps the watchdog from expiring by writing the byte again. Any write starts the interval over.

When the interval runs out, the block sets a sticky flag. The steering bit then picks one of two actions:

- **Reset mode:** the block drives a reset pulse of fixed length and clears its configuration, which leaves the watchdog off.
- **Interrupt mode:** the block raises an interrupt line. The line stays high until the host writes the byte again.

A power-fail input disarms the whole block. Software must therefore arm it again after boot.

Top module: `wdog_steer_top`

## Requirements
- R1: A write strobe `wr_en` loads `wr_data` into the configuration register, which reads back on `cfg_o` from the next cycle. Bit 7 is steering (1 = reset pulse, 0 = interrupt). Bits 6..2 are the multiplier M. Bits 1..0 are the resolution code.
- R2: For codes 00 and 01 the resolution unit is one and four `tick16` pulses. The timeout expires on the edge that samples the M-th unit, and the 1 Hz tick has no effect.
- R3: For codes 10 and 11 the resolution unit is one and four `tick1` pulses. The timeout expires on the M-th unit, and the 16 Hz tick has no effect.
- R4: A multiplier of zero disables the watchdog. No number of ticks causes an expiry.
- R5: In reset mode, an expiry drives `rst_pulse_o` high for exactly PULSE_LEN cycles, starting the cycle after the expiring edge. The configuration register reads zero from that same cycle, so no further expiry follows.
- R6: In interrupt mode, an expiry raises `irq_o`. It stays high until a write or a power failure. Counting continues from zero while it is high.
- R7: Every expiry sets `flag_o`. A `flag_rd` strobe clears it. If an expiry and `flag_rd` occur in the same cycle, the flag ends up set.
- R8: A write restarts the timeout and discards any partial progress. A write in the same cycle as an expiring tick wins, and no expiry occurs.
- R9: While `pwr_fail` is high, the configuration register, the count and `irq_o` are cleared, and writes are ignored.
- R10: After reset, `cfg_o`, `irq_o`, `rst_pulse_o` and `flag_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16 Hz enable, one cycle wide |
| tick1 | input | 1 | 1 Hz enable, one cycle wide |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration byte |
| flag_rd | input | 1 | Flag read strobe; clears the flag |
| pwr_fail | input | 1 | Power-fail indication, disarms the block |
| cfg_o | output | 8 | Current configuration register |
| irq_o | output | 1 | Latched timeout interrupt |
| rst_pulse_o | output | 1 | Timeout reset pulse |
| flag_o | output | 1 | Sticky timeout flag |

## Verification
Each input is registered exactly once on its way to an output:

- A write, a power failure or a flag read is visible on the outputs one cycle after the edge that samples it.
- An expiry shows on `irq_o`, `flag_o`, `rst_pulse_o` and `cfg_o` one cycle after the edge that samples the final tick.
- The reset pulse then stays high for PULSE_LEN cycles.

The bench drives every stimulus for one cycle starting on a falling edge and samples on the following falling edge, which is the first point where the result is due. It checks the "not yet" case one tick before each expiry. It counts reset-pulse cycles over a window longer than the pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CFG_W  = 8;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int DIV    = 4;
    localparam int SUB_W  = $clog2(DIV);

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } cfg_t;
endpackage

// File: rtl/wdog_unit_gen.sv
module wdog_unit_gen
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [RES_W-1:0] res,
    input  logic             tick16,
    input  logic             tick1,
    output logic             unit_o
);
    logic [SUB_W-1:0] sub_d, sub_q;
    logic             base;
    logic             div_on;

    always_comb begin
        base   = res[1] ? tick1 : tick16;
        div_on = res[0];
        sub_d  = sub_q;
        unit_o = 1'b0;
        if (restart) begin
            sub_d = '0;
        end else if (base) begin
            if (!div_on) begin
                unit_o = 1'b1;
            end else if (sub_q == SUB_W'(DIV - 1)) begin
                unit_o = 1'b1;
                sub_d  = '0;
            end else begin
                sub_d = sub_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)               cnt_d = PW'(PULSE_LEN);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/wdog_steer_top.sv
module wdog_steer_top
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             tick1,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             flag_rd,
    input  logic             pwr_fail,
    output logic [CFG_W-1:0] cfg_o,
    output logic             irq_o,
    output logic             rst_pulse_o,
    output logic             flag_o
);
    typedef struct packed {
        cfg_t              cfg;
        logic [MULT_W-1:0] cnt;
        logic              irq;
        logic              flag;
    } st_t;

    st_t  st_d, st_q;
    logic restart;
    logic unit;
    logic expire;
    logic start_pulse;

    wdog_unit_gen u_unit (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .res    (st_q.cfg.res),
        .tick16 (tick16),
        .tick1  (tick1),
        .unit_o (unit)
    );

    wdog_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_pulse),
        .pulse_o(rst_pulse_o)
    );

    always_comb begin
        restart     = wr_en | pwr_fail | (st_q.cfg.mult == '0);
        expire      = !restart && unit && (st_q.cnt == st_q.cfg.mult - 1'b1);
        start_pulse = expire && st_q.cfg.steer;
        st_d        = st_q;

        if (pwr_fail) begin
            st_d.cfg = '0;
            st_d.cnt = '0;
            st_d.irq = 1'b0;
        end else if (wr_en) begin
            st_d.cfg = cfg_t'(wr_data);
            st_d.cnt = '0;
            st_d.irq = 1'b0;
        end else if (st_q.cfg.mult == '0) begin
            st_d.cnt = '0;
        end else if (expire) begin
            st_d.cnt = '0;
            if (st_q.cfg.steer) st_d.cfg = '0;
            else                st_d.irq = 1'b1;
        end else if (unit) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (expire)       st_d.flag = 1'b1;
        else if (flag_rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign irq_o  = st_q.irq;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       flag_rd,
    input logic       pwr_fail,
    input logic [7:0] cfg_o,
    input logic       irq_o,
    input logic       rst_pulse_o,
    input logic       flag_o
);
    a_r5_cfg_cleared_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse_o) |-> (cfg_o == 8'h00));

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en && !pwr_fail) |=> irq_o);

    a_r7_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) || $rose(rst_pulse_o)) |-> flag_o);

    a_r9_pwr_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (cfg_o == 8'h00 && !irq_o));

    a_r4_zero_mult_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[6:2] == 5'd0 && !wr_en) |=> (!$rose(irq_o) && !$rose(rst_pulse_o)));

    a_r1_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pwr_fail) |=> (cfg_o == $past(wr_data)));

    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !$rose(irq_o)) |=> (!flag_o || irq_o || rst_pulse_o));
endmodule

bind wdog_steer_top wdog_steer_chk u_chk (.*);

// File: tb/sim_wdog_steer_top.sv
module sim_wdog_steer_top;
    localparam int PL = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0, tick1 = 1'b0, wr_en = 1'b0, flag_rd = 1'b0, pwr_fail = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cfg_o;
    logic       irq_o, rst_pulse_o, flag_o;
    int         errs = 0, checks = 0;

    always #2.5 clk = ~clk;

    wdog_steer_top #(.PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .tick1(tick1),
        .wr_en(wr_en), .wr_data(wr_data), .flag_rd(flag_rd), .pwr_fail(pwr_fail),
        .cfg_o(cfg_o), .irq_o(irq_o), .rst_pulse_o(rst_pulse_o), .flag_o(flag_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic t16(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick16 = 1'b1;
            @(negedge clk); tick16 = 1'b0;
        end
    endtask

    task automatic t1(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick1 = 1'b1;
            @(negedge clk); tick1 = 1'b0;
        end
    endtask

    task automatic test_reset;
        chk("R10 cfg", cfg_o, 0);
        chk("R10 irq", irq_o, 0);
        chk("R10 pulse", rst_pulse_o, 0);
        chk("R10 flag", flag_o, 0);
    endtask

    task automatic test_code00;
        wr(8'h0C);
        chk("R1 readback", cfg_o, 8'h0C);
        t16(2);
        chk("R2 code00 early", irq_o, 0);
        t16(1);
        chk("R2 code00 expiry", irq_o, 1);
        chk("R7 flag set", flag_o, 1);
        repeat (5) @(negedge clk);
        chk("R6 irq sticky", irq_o, 1);
        wr(8'h0C);
        chk("R6 irq cleared by write", irq_o, 0);
    endtask

    task automatic test_code01;
        wr(8'h09);
        t16(7);
        chk("R2 code01 early", irq_o, 0);
        t16(1);
        chk("R2 code01 expiry", irq_o, 1);
    endtask

    task automatic test_code10;
        wr(8'h0E);
        t16(20);
        chk("R3 tick16 ignored", irq_o, 0);
        t1(2);
        chk("R3 code10 early", irq_o, 0);
        t1(1);
        chk("R3 code10 expiry", irq_o, 1);
    endtask

    task automatic test_code11;
        wr(8'h07);
        t1(3);
        chk("R3 code11 early", irq_o, 0);
        t1(1);
        chk("R3 code11 expiry", irq_o, 1);
    endtask

    task automatic test_steer;
        int hi = 0;
        wr(8'h88);
        t16(1);
        chk("R5 no pulse early", rst_pulse_o, 0);
        @(negedge clk); tick16 = 1'b1;
        @(negedge clk); tick16 = 1'b0;
        chk("R5 pulse starts", rst_pulse_o, 1);
        chk("R5 cfg cleared", cfg_o, 0);
        chk("R6 no irq in reset mode", irq_o, 0);
        chk("R7 flag on pulse", flag_o, 1);
        hi = 1;
        for (int i = 0; i < PL + 4; i++) begin
            @(negedge clk);
            if (rst_pulse_o) hi++;
        end
        chk("R5 pulse length", hi, PL);
        t16(6);
        chk("R5 disarmed after pulse", rst_pulse_o, 0);
    endtask

    task automatic test_zero;
        wr(8'h00);
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
        chk("R7 flag cleared", flag_o, 0);
        wr(8'h03);
        t1(6); t16(6);
        chk("R4 mult zero irq", irq_o, 0);
        chk("R4 mult zero flag", flag_o, 0);
    endtask

    task automatic test_restart;
        wr(8'h0C);
        t16(2);
        wr(8'h0C);
        t16(2);
        chk("R8 restart discards progress", irq_o, 0);
        @(negedge clk); tick16 = 1'b1; wr_en = 1'b1; wr_data = 8'h0C;
        @(negedge clk); tick16 = 1'b0; wr_en = 1'b0;
        chk("R8 write beats expiry", irq_o, 0);
        t16(2);
        chk("R8 count from write", irq_o, 0);
        t16(1);
        chk("R8 expiry after restart", irq_o, 1);
    endtask

    task automatic test_pwr;
        @(negedge clk); pwr_fail = 1'b1; wr_en = 1'b1; wr_data = 8'h04;
        @(negedge clk); pwr_fail = 1'b0; wr_en = 1'b0;
        chk("R9 cfg cleared", cfg_o, 0);
        chk("R9 irq cleared", irq_o, 0);
        t16(4);
        chk("R9 stays disarmed", irq_o, 0);
    endtask

    task automatic test_flag_race;
        wr(8'h04);
        @(negedge clk); flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
        chk("R7 flag clear", flag_o, 0);
        @(negedge clk); tick16 = 1'b1; flag_rd = 1'b1;
        @(negedge clk); tick16 = 1'b0; flag_rd = 1'b0;
        chk("R7 set wins over read", flag_o, 1);
    endtask

    initial begin
        #200000;
        errs++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_code00();
        test_code01();
        test_code10();
        test_code11();
        test_steer();
        test_zero();
        test_restart();
        test_pwr();
        test_flag_race();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule